// File: doc/BRIEF.md
# Bad-Block-Skipping Flash Image Loader

This controller copies an image of fixed length from a NAND flash into memory, one page at a time, and skips damaged erase blocks as it goes. A single `start` pulse captures five inputs: the byte offset of the image in flash, the image length in bytes, the page size, the block size and the memory base address. The controller then works out the first page and the number of pages to copy. After that it steps a page cursor and a destination address until that many good pages have been delivered. The flash bus, the error-correction arithmetic and any transfer of control to the loaded code are handled by neighbouring blocks. The loader reaches them through three request/acknowledge channels:

- **spare-byte fetch**: returns one byte from a page's spare area.
- **page read**: moves a page of data to a memory address.
- **sector correction**: corrects one 512-byte sector of a page in place, using parity bytes that it takes from the spare area.

Each channel holds its request high until a one-cycle acknowledge arrives. Only one channel is active at a time.

Page size is coded as `page_sel`: 0 gives 512 bytes, 1 gives 1024, 2 gives 2048 and 3 gives 4096. The page size is therefore 512 << `page_sel`, and the spare area is one thirty-second of it. A block holds 2^`blk_shift` pages.

The state machine has seven states:

| State | Behaviour |
|---|---|
| IDLE | After reset; waits for `start`. |
| PICK | Decides the next action. |
| MARK | Fetches the marker byte of a block's first page. |
| READ | Issues the page read. |
| ECC | Walks the sectors of the page. |
| NEXT | Advances the cursor. |
| DONE | Holds the result until a new `start`. |

The transitions are:

- IDLE→PICK and DONE→PICK on `start`.
- PICK→DONE when the copied count equals the target.
- PICK→MARK when the cursor sits on the first page of a block.
- PICK→READ on any other page.
- MARK→PICK on a bad marker; the cursor jumps one block.
- MARK→READ on a good marker.
- READ→ECC on the read acknowledge.
- ECC→ECC on the acknowledge of a sector that is not the last.
- ECC→NEXT on the acknowledge of the last sector.
- NEXT→PICK always.

Top module: `nand_image_loader`

## Requirements
- R1: On `start` the cursor page becomes offset >> (9 + page_sel), rounded down. The target count becomes image length >> (9 + page_sel). A target of zero reaches DONE without issuing any request.
- R2: A spare-byte fetch is issued only when the cursor page is a multiple of 2^blk_shift, and it is issued before any read of that page. The byte column requested is 5 when page_sel = 0 and 0 for every larger page.
- R3: A block whose marker byte is any value other than 8'hFF is skipped. The cursor advances by 2^blk_shift pages, the copied count is unchanged, and no page or sector request is issued for that block.
- R4: A good page is read with `rd_page` equal to the cursor page and `rd_dst` equal to the current destination address. The first destination is `dst_base`.
- R5: After each page read, 2^page_sel sector requests follow in ascending order from 0. Sector i carries parity column 6 + 9·i and memory address `rd_dst` + 512·i. Its nine parity bytes lie inside the spare area.
- R6: After the last sector of a page is acknowledged, the destination grows by the page size, the cursor page grows by one, and the copied count grows by one.
- R7: `flash_ce` is high from the cycle after `start` until the copied count reaches the target. At that point `done` rises and `flash_ce` falls in the same cycle. `done` then holds with no requests until the next `start`.
- R8: Requests are mutually exclusive, and each is held high until its acknowledge is seen.
- R9: After reset the loader is idle, with `done`, `flash_ce` and all requests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (accepted in IDLE or DONE) |
| offset | input | OFS_W | Byte offset of the image in flash |
| img_bytes | input | OFS_W | Image length in bytes |
| dst_base | input | ADDR_W | Memory address of the first page |
| page_sel | input | SEL_W | Page size code, size = 512 << page_sel |
| blk_shift | input | BSH_W | log2 of pages per erase block |
| flash_ce | output | 1 | Flash chip enable, high while loading |
| done | output | 1 | Load complete |
| spr_req | output | 1 | Spare-byte fetch request |
| spr_page | output | PAGE_W | Page for the spare fetch |
| spr_col | output | COL_W | Byte column inside the spare area |
| spr_ack | input | 1 | Spare fetch acknowledge, data valid |
| spr_data | input | 8 | Fetched spare byte |
| rd_req | output | 1 | Page read request |
| rd_page | output | PAGE_W | Page to read |
| rd_dst | output | ADDR_W | Memory address for the page |
| rd_ack | input | 1 | Page read acknowledge |
| ecc_req | output | 1 | Sector correction request |
| ecc_sector | output | SEC_W | Sector index inside the page |
| ecc_par_col | output | COL_W | Spare column of the sector's first parity byte |
| ecc_dst | output | ADDR_W | Memory address of the sector |
| ecc_ack | input | 1 | Sector correction acknowledge |

## Verification
The assertions depend on four assumptions about the inputs:

- `offset`, `img_bytes`, `dst_base`, `page_sel` and `blk_shift` are held stable while a load runs.
- Every acknowledge is a single-cycle pulse given only while the matching request is high.
- `page_sel` is never so large that the sector index wraps.
- `blk_shift` is small enough that one block still fits in the page counter.

The bench responds to the three channels from a single process. It raises an acknowledge only on a live request, with a delay of 0 to 2 cycles, and drops it on the following cycle. It changes the configuration only after `done`. It sweeps all four page sizes, three block sizes and three bad-block patterns, and it uses offsets that do and do not fall on a block boundary.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_MARK,
        ST_READ,
        ST_ECC,
        ST_NEXT,
        ST_DONE
    } ldr_state_e;

    localparam int SECT_SHIFT     = 9;      // 512-byte correction sectors
    localparam int PAR_BASE       = 6;      // first parity byte in spare area
    localparam int PAR_LEN        = 9;      // parity bytes per sector
    localparam int SMALL_MARK_COL = 5;      // marker column for 512-byte pages
    localparam int LARGE_MARK_COL = 0;      // marker column for larger pages
    localparam logic [7:0] MARK_GOOD = 8'hFF;

endpackage

// File: rtl/ldr_geom.sv
module ldr_geom
    import ldr_pkg::*;
#(
    parameter int OFS_W   = 32,
    parameter int PAGE_W  = 24,
    parameter int CNT_W   = 16,
    parameter int SEL_W   = 2,
    parameter int COL_W   = 8,
    parameter int SEC_W   = 3,
    parameter int SHIFT_W = 4
) (
    input  logic [OFS_W-1:0]   offset,
    input  logic [OFS_W-1:0]   img_bytes,
    input  logic [SEL_W-1:0]   page_sel,
    output logic [PAGE_W-1:0]  first_page,
    output logic [CNT_W-1:0]   target_pages,
    output logic [SHIFT_W-1:0] page_shift,
    output logic [SEC_W-1:0]   last_sector,
    output logic [COL_W-1:0]   mark_col
);
    logic [OFS_W-1:0] page_full;
    logic [OFS_W-1:0] count_full;
    logic [SEC_W:0]   sector_count;

    always_comb begin
        page_shift   = SHIFT_W'(SECT_SHIFT) + SHIFT_W'(page_sel);
        page_full    = offset >> page_shift;
        count_full   = img_bytes >> page_shift;
        first_page   = page_full[PAGE_W-1:0];
        target_pages = count_full[CNT_W-1:0];
        sector_count = (SEC_W+1)'(1) << page_sel;
        last_sector  = SEC_W'(sector_count - (SEC_W+1)'(1));
        mark_col     = (page_sel == '0) ? COL_W'(SMALL_MARK_COL)
                                        : COL_W'(LARGE_MARK_COL);
    end
endmodule

// File: rtl/ldr_cursor.sv
module ldr_cursor #(
    parameter int ADDR_W  = 32,
    parameter int PAGE_W  = 24,
    parameter int CNT_W   = 16,
    parameter int BSH_W   = 3,
    parameter int SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               skip_blk,
    input  logic               adv_page,
    input  logic [PAGE_W-1:0]  first_page,
    input  logic [ADDR_W-1:0]  dst_base,
    input  logic [SHIFT_W-1:0] page_shift,
    input  logic [BSH_W-1:0]   blk_shift,
    output logic [PAGE_W-1:0]  cur_page,
    output logic [ADDR_W-1:0]  cur_dst,
    output logic [CNT_W-1:0]   copied,
    output logic               blk_first
);
    logic [PAGE_W-1:0] blk_pages;
    logic [PAGE_W-1:0] blk_mask;

    always_comb begin
        blk_pages = PAGE_W'(1) << blk_shift;
        blk_mask  = blk_pages - PAGE_W'(1);
        blk_first = ((cur_page & blk_mask) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_page <= '0;
            cur_dst  <= '0;
            copied   <= '0;
        end else if (load) begin
            cur_page <= first_page;
            cur_dst  <= dst_base;
            copied   <= '0;
        end else if (skip_blk) begin
            cur_page <= cur_page + blk_pages;
        end else if (adv_page) begin
            cur_page <= cur_page + PAGE_W'(1);
            cur_dst  <= cur_dst + (ADDR_W'(1) << page_shift);
            copied   <= copied + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ldr_sector.sv
module ldr_sector
    import ldr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEC_W  = 3,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [SEC_W-1:0]  last_idx,
    input  logic [ADDR_W-1:0] page_dst,
    output logic [SEC_W-1:0]  sec_idx,
    output logic [COL_W-1:0]  par_col,
    output logic [ADDR_W-1:0] sec_dst,
    output logic              sec_last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_idx <= '0;
            par_col <= COL_W'(PAR_BASE);
        end else if (clear) begin
            sec_idx <= '0;
            par_col <= COL_W'(PAR_BASE);
        end else if (step) begin
            sec_idx <= sec_idx + SEC_W'(1);
            par_col <= par_col + COL_W'(PAR_LEN);
        end
    end

    always_comb begin
        sec_dst  = page_dst + (ADDR_W'(sec_idx) << SECT_SHIFT);
        sec_last = (sec_idx == last_idx);
    end
endmodule

// File: rtl/nand_image_loader.sv
module nand_image_loader
    import ldr_pkg::*;
#(
    parameter int OFS_W  = 32,
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 24,
    parameter int CNT_W  = 16,
    parameter int BSH_W  = 3,
    parameter int SEL_W  = 2,
    parameter int COL_W  = 8,
    localparam int SEC_W   = (1 << SEL_W) - 1,
    localparam int SHIFT_W = $clog2(SECT_SHIFT + (1 << SEL_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OFS_W-1:0]  offset,
    input  logic [OFS_W-1:0]  img_bytes,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [SEL_W-1:0]  page_sel,
    input  logic [BSH_W-1:0]  blk_shift,
    output logic              flash_ce,
    output logic              done,
    output logic              spr_req,
    output logic [PAGE_W-1:0] spr_page,
    output logic [COL_W-1:0]  spr_col,
    input  logic              spr_ack,
    input  logic [7:0]        spr_data,
    output logic              rd_req,
    output logic [PAGE_W-1:0] rd_page,
    output logic [ADDR_W-1:0] rd_dst,
    input  logic              rd_ack,
    output logic              ecc_req,
    output logic [SEC_W-1:0]  ecc_sector,
    output logic [COL_W-1:0]  ecc_par_col,
    output logic [ADDR_W-1:0] ecc_dst,
    input  logic              ecc_ack
);
    ldr_state_e state_q, state_d;

    logic [PAGE_W-1:0]  g_first_page;
    logic [CNT_W-1:0]   g_target;
    logic [SHIFT_W-1:0] g_shift;
    logic [SEC_W-1:0]   g_last;
    logic [COL_W-1:0]   g_mcol;

    logic [CNT_W-1:0]   target_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [SEC_W-1:0]   last_q;
    logic [COL_W-1:0]   mcol_q;
    logic [BSH_W-1:0]   bsh_q;

    logic [PAGE_W-1:0]  cur_page;
    logic [ADDR_W-1:0]  cur_dst;
    logic [CNT_W-1:0]   copied;
    logic               blk_first;
    logic               sec_last;

    logic load, skip_blk, adv_page, sec_clear, sec_step, marker_bad;

    ldr_geom #(
        .OFS_W(OFS_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W), .SEL_W(SEL_W),
        .COL_W(COL_W), .SEC_W(SEC_W), .SHIFT_W(SHIFT_W)
    ) geom_i (
        .offset(offset), .img_bytes(img_bytes), .page_sel(page_sel),
        .first_page(g_first_page), .target_pages(g_target),
        .page_shift(g_shift), .last_sector(g_last), .mark_col(g_mcol)
    );

    ldr_cursor #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W),
        .BSH_W(BSH_W), .SHIFT_W(SHIFT_W)
    ) cursor_i (
        .clk(clk), .rst_n(rst_n), .load(load), .skip_blk(skip_blk),
        .adv_page(adv_page), .first_page(g_first_page), .dst_base(dst_base),
        .page_shift(shift_q), .blk_shift(bsh_q), .cur_page(cur_page),
        .cur_dst(cur_dst), .copied(copied), .blk_first(blk_first)
    );

    ldr_sector #(
        .ADDR_W(ADDR_W), .SEC_W(SEC_W), .COL_W(COL_W)
    ) sector_i (
        .clk(clk), .rst_n(rst_n), .clear(sec_clear), .step(sec_step),
        .last_idx(last_q), .page_dst(cur_dst), .sec_idx(ecc_sector),
        .par_col(ecc_par_col), .sec_dst(ecc_dst), .sec_last(sec_last)
    );

    // Configuration captured at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '0;
            shift_q  <= '0;
            last_q   <= '0;
            mcol_q   <= '0;
            bsh_q    <= '0;
        end else if (load) begin
            target_q <= g_target;
            shift_q  <= g_shift;
            last_q   <= g_last;
            mcol_q   <= g_mcol;
            bsh_q    <= blk_shift;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_PICK;
            ST_PICK: begin
                if (copied == target_q) state_d = ST_DONE;
                else if (blk_first)     state_d = ST_MARK;
                else                    state_d = ST_READ;
            end
            ST_MARK: if (spr_ack) state_d = marker_bad ? ST_PICK : ST_READ;
            ST_READ: if (rd_ack)  state_d = ST_ECC;
            ST_ECC:  if (ecc_ack && sec_last) state_d = ST_NEXT;
            ST_NEXT: state_d = ST_PICK;
            ST_DONE: if (start) state_d = ST_PICK;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath strobes
    always_comb begin
        marker_bad = (spr_data != MARK_GOOD);
        load      = 1'b0;
        skip_blk  = 1'b0;
        adv_page  = 1'b0;
        sec_clear = 1'b0;
        sec_step  = 1'b0;
        spr_req   = 1'b0;
        rd_req    = 1'b0;
        ecc_req   = 1'b0;
        flash_ce  = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                flash_ce = 1'b0;
                load     = start;
            end
            ST_PICK: ;
            ST_MARK: begin
                spr_req  = 1'b1;
                skip_blk = spr_ack && marker_bad;
            end
            ST_READ: begin
                rd_req    = 1'b1;
                sec_clear = 1'b1;
            end
            ST_ECC: begin
                ecc_req  = 1'b1;
                sec_step = ecc_ack && !sec_last;
            end
            ST_NEXT: adv_page = 1'b1;
            ST_DONE: begin
                flash_ce = 1'b0;
                done     = 1'b1;
                load     = start;
            end
            default: flash_ce = 1'b0;
        endcase
        spr_page = cur_page;
        spr_col  = mcol_q;
        rd_page  = cur_page;
        rd_dst   = cur_dst;
    end
endmodule

// File: rtl/nand_image_loader_chk.sv
module nand_image_loader_chk #(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 24,
    parameter int BSH_W  = 3,
    parameter int SEL_W  = 2,
    parameter int COL_W  = 8,
    parameter int SEC_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [SEL_W-1:0]  page_sel,
    input logic [BSH_W-1:0]  blk_shift,
    input logic              flash_ce,
    input logic              done,
    input logic              spr_req,
    input logic [PAGE_W-1:0] spr_page,
    input logic              spr_ack,
    input logic              rd_req,
    input logic              rd_ack,
    input logic              ecc_req,
    input logic [SEC_W-1:0]  ecc_sector,
    input logic [COL_W-1:0]  ecc_par_col,
    input logic              ecc_ack
);
    logic [PAGE_W-1:0] blk_mask;
    assign blk_mask = (PAGE_W'(1) << blk_shift) - PAGE_W'(1);

    assert_spr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spr_req && !spr_ack |=> spr_req);
    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req);
    assert_ecc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_req && !ecc_ack |=> ecc_req);
    assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({spr_req, rd_req, ecc_req}) <= 1);
    assert_ce_off_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flash_ce);
    assert_ce_on_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_req || rd_req || ecc_req) |-> flash_ce);
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);
    assert_mark_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spr_req |-> ((spr_page & blk_mask) == '0));
    assert_par_in_spare_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_req |-> (int'(ecc_par_col) + 9 <= (16 << page_sel)));
    assert_sector_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_req && ecc_ack |=> (!ecc_req || ecc_sector == SEC_W'($past(ecc_sector) + 1'b1)));
endmodule

bind nand_image_loader nand_image_loader_chk #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BSH_W(BSH_W),
    .SEL_W(SEL_W), .COL_W(COL_W), .SEC_W(SEC_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .page_sel(page_sel),
    .blk_shift(blk_shift), .flash_ce(flash_ce), .done(done),
    .spr_req(spr_req), .spr_page(spr_page), .spr_ack(spr_ack),
    .rd_req(rd_req), .rd_ack(rd_ack), .ecc_req(ecc_req),
    .ecc_sector(ecc_sector), .ecc_par_col(ecc_par_col), .ecc_ack(ecc_ack)
);

// File: tb/nand_image_loader_tb_top.sv
module nand_image_loader_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        start = 1'b0;
    logic [31:0] offset = '0, img_bytes = '0, dst_base = '0;
    logic [1:0]  page_sel = '0;
    logic [2:0]  blk_shift = 3'd1;
    logic        flash_ce, done;
    logic        spr_req, rd_req, ecc_req;
    logic [23:0] spr_page, rd_page;
    logic [7:0]  spr_col, ecc_par_col;
    logic [31:0] rd_dst, ecc_dst;
    logic [2:0]  ecc_sector;
    logic        spr_ack = 1'b0, rd_ack = 1'b0, ecc_ack = 1'b0;
    logic [7:0]  spr_data = 8'hFF;

    nand_image_loader dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .offset(offset),
        .img_bytes(img_bytes), .dst_base(dst_base), .page_sel(page_sel),
        .blk_shift(blk_shift), .flash_ce(flash_ce), .done(done),
        .spr_req(spr_req), .spr_page(spr_page), .spr_col(spr_col),
        .spr_ack(spr_ack), .spr_data(spr_data), .rd_req(rd_req),
        .rd_page(rd_page), .rd_dst(rd_dst), .rd_ack(rd_ack),
        .ecc_req(ecc_req), .ecc_sector(ecc_sector), .ecc_par_col(ecc_par_col),
        .ecc_dst(ecc_dst), .ecc_ack(ecc_ack)
    );

    int n_checks = 0, n_fail = 0;
    int bad_mode = 0;
    int exp_kind [0:1023];
    int exp_a    [0:1023];
    int exp_b    [0:1023];
    longint exp_c[0:1023];
    int exp_n = 0, ev_idx = 0, dly = 0;

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_bad(int blk);
        if (bad_mode == 1) return (blk % 3) == 1;
        if (bad_mode == 2) return blk == 1 || blk == 2 || blk == 5;
        return 1'b0;
    endfunction

    task automatic add_ev(int k, int a, int b, longint c);
        exp_kind[exp_n] = k; exp_a[exp_n] = a; exp_b[exp_n] = b; exp_c[exp_n] = c;
        exp_n++;
    endtask

    // Expected request stream computed from the requirements
    task automatic build_expect();
        int ps = 9 + int'(page_sel);
        int ppb = 1 << blk_shift;
        int page = int'(offset >> ps);
        int tgt = int'(img_bytes >> ps);
        int cnt = 0;
        longint dst = longint'(dst_base);
        exp_n = 0;
        while (cnt < tgt && exp_n < 900) begin
            if (page % ppb == 0) begin
                add_ev(0, page, (page_sel == 0) ? 5 : 0, 0);
                if (is_bad(page / ppb)) begin
                    page += ppb;
                    continue;
                end
            end
            add_ev(1, page, 0, dst);
            for (int i = 0; i < (1 << page_sel); i++)
                add_ev(2, i, 6 + 9 * i, dst + 512 * i);
            dst += longint'(1) << ps;
            page++;
            cnt++;
        end
    endtask

    // Responder for all three channels
    initial begin
        forever begin
            @(negedge clk);
            if (spr_ack || rd_ack || ecc_ack) begin
                spr_ack = 1'b0; rd_ack = 1'b0; ecc_ack = 1'b0;
            end else if (spr_req || rd_req || ecc_req) begin
                if (dly > 0) dly--;
                else begin
                    check(int'(spr_req) + int'(rd_req) + int'(ecc_req) == 1 && flash_ce,
                          "R8 R7 single request with chip enable",
                          {spr_req, rd_req, ecc_req, flash_ce}, 4'b0);
                    if (ev_idx >= exp_n) begin
                        check(1'b0, "R1 R7 unexpected request", ev_idx, exp_n);
                    end else if (spr_req) begin
                        check(exp_kind[ev_idx] == 0 && int'(spr_page) == exp_a[ev_idx]
                              && int'(spr_col) == exp_b[ev_idx],
                              "R2 R3 spare fetch page/col",
                              {exp_kind[ev_idx], spr_page, spr_col},
                              {exp_kind[ev_idx] == 0 ? 32'd0 : 32'd9, exp_a[ev_idx][23:0], exp_b[ev_idx][7:0]});
                        spr_data = !is_bad(int'(spr_page >> blk_shift)) ? 8'hFF
                                 : (spr_page[blk_shift] ? 8'hFE : 8'h00);
                        spr_ack = 1'b1;
                    end else if (rd_req) begin
                        check(exp_kind[ev_idx] == 1 && int'(rd_page) == exp_a[ev_idx]
                              && longint'(rd_dst) == exp_c[ev_idx],
                              "R1 R4 R6 page read page/dst",
                              {rd_page, rd_dst}, {exp_a[ev_idx][23:0], exp_c[ev_idx][31:0]});
                        rd_ack = 1'b1;
                    end else begin
                        check(exp_kind[ev_idx] == 2 && int'(ecc_sector) == exp_a[ev_idx]
                              && int'(ecc_par_col) == exp_b[ev_idx]
                              && longint'(ecc_dst) == exp_c[ev_idx],
                              "R5 sector idx/parity/dst",
                              {ecc_sector, ecc_par_col, ecc_dst},
                              {exp_a[ev_idx][2:0], exp_b[ev_idx][7:0], exp_c[ev_idx][31:0]});
                        ecc_ack = 1'b1;
                    end
                    ev_idx++;
                    dly = ev_idx % 3;
                end
            end
        end
    end

    task automatic run_load(int sel, int bs, int mode, int off, int len, int base);
        int cyc = 0;
        page_sel = 2'(sel); blk_shift = 3'(bs); bad_mode = mode;
        offset = 32'(off); img_bytes = 32'(len); dst_base = 32'(base);
        build_expect();
        ev_idx = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            check(1'b0, "R7 watchdog waiting for done", cyc, 20000);
            rst_n = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            return;
        end
        check(done && !flash_ce, "R7 done with chip enable low", {done, flash_ce}, 2'b10);
        check(ev_idx == exp_n, "R1 R3 R7 request count at done", ev_idx, exp_n);
        repeat (3) @(negedge clk);
        check(done && !flash_ce && !spr_req && !rd_req && !ecc_req && ev_idx == exp_n,
              "R7 done holds quietly", {done, flash_ce, ev_idx}, {1'b1, 1'b0, exp_n});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !flash_ce && !spr_req && !rd_req && !ecc_req,
              "R9 reset state", {done, flash_ce, spr_req, rd_req, ecc_req}, 5'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done && !flash_ce && !spr_req && !rd_req && !ecc_req,
              "R9 idle after reset", {done, flash_ce, spr_req, rd_req, ecc_req}, 5'b0);

        for (int sel = 0; sel < 4; sel++)
            for (int bs = 1; bs < 4; bs++)
                for (int mode = 0; mode < 3; mode++) begin
                    int pg = 512 << sel;
                    int ppb = 1 << bs;
                    int off = ((sel + bs + mode) % 2 == 0) ? (ppb * pg + 3)
                                                           : (pg * (ppb - 1) + 17);
                    run_load(sel, bs, mode, off, 5 * pg + 11,
                             32'h1000_0000 + sel * 32'h10_0000 + bs * 32'h1000);
                end

        // R1: image shorter than a page copies nothing
        run_load(0, 2, 1, 700, 511, 32'h2000_0000);
        run_load(3, 1, 0, 0, 4095, 32'h2000_0000);
        // R3: consecutive bad blocks from offset zero
        run_load(1, 1, 2, 0, 3 * 1024, 32'h3000_0000);
        run_load(2, 3, 1, 0, 12 * 2048, 32'h3100_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule